// File: doc/BRIEF.md
# Button-Stepped Decimal Counter Display

The block keeps a running decimal total that an operator advances with three active-low push buttons. One button adds one, another adds ten and the third adds a hundred. The raw button bus passes through a single register stage. A second register keeps the previous registered value. A step is taken only when these two differ, so each change of the registered button state adds its step exactly once, however long the button is held. The total lives in a 16-bit register, stays in the range 0 to 9999 and wraps modulo 10000.

The registered total goes through a combinational shift-and-add-3 binary-to-BCD converter. Each of the four decimal digits is then encoded for an active-low seven-segment display. A synchronous, active-high reset clears the total, and a LED output follows reset. The segment encoder also maps any digit code above nine to the all-off pattern. The wrap keeps the total from ever producing such a code.

Top module: `step_count_display`

## Requirements
- R1: While `rst` is high at a rising edge, the total is cleared to 0 and all four digits show the zero pattern after that edge. `rst_led` is 1 while `rst` is 1 and 0 while `rst` is 0.
- R2: `btn_n` code 3'b110 (bit 0 low) adds 1, 3'b101 (bit 1 low) adds 10, and 3'b011 (bit 2 low) adds 100.
- R3: Every other code adds 0. This covers 3'b111 (released) and codes with two or three bits low.
- R4: A step is applied once per change of the registered button state. Holding a code unchanged for further cycles leaves the total unchanged.
- R5: After `btn_n` changes, the total and the segments are unchanged after the first rising edge and show the new value after the second rising edge.
- R6: A step that would take the total above 9999 wraps it modulo 10000. For example, 9999 + 1 gives 0.
- R7: The four digit outputs show the total in decimal: `seg_thou` is the thousands digit and `seg_ones` is the ones digit.
- R8: Segment patterns are active-low, with bit 7 first: 0=00000011, 1=10011111, 2=00100101, 3=00001101, 4=10011001, 5=01001001, 6=01000001, 7=00011111, 8=00000001, 9=00011001.
- R9: Both button registers reset to 3'b111. A single-button code held through reset therefore adds its step exactly once after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_n | input | 3 | Active-low buttons: bit 0 = +1, bit 1 = +10, bit 2 = +100 |
| seg_thou | output | 8 | Active-low segments, thousands digit |
| seg_hund | output | 8 | Active-low segments, hundreds digit |
| seg_tens | output | 8 | Active-low segments, tens digit |
| seg_ones | output | 8 | Active-low segments, ones digit |
| rst_led | output | 1 | High while reset is asserted |

## Verification
The hardest cases to reach from the ports are the wrap from 9999 and the full set of digit patterns. Both need thousands of accepted presses. The bench drives ten thousand press-and-release pairs of the +1 button. It compares all four segment outputs against an arithmetic model after every press, so every total from 0 to 9999 and the return to 0 are checked. Separate short sequences check the two-edge latency, held buttons, multi-button codes, direct code-to-code changes, and a button held through reset.

// File: rtl/step_count_pkg.sv
package step_count_pkg;
  localparam int BTN_W   = 3;
  localparam int STEP_W  = 7;
  localparam int TOTAL_W = 16;
  localparam int DIGITS  = 4;
  localparam int LIMIT   = 10000;

  localparam logic [BTN_W-1:0] CODE_ONE     = 3'b110;
  localparam logic [BTN_W-1:0] CODE_TEN     = 3'b101;
  localparam logic [BTN_W-1:0] CODE_HUNDRED = 3'b011;
  localparam logic [BTN_W-1:0] CODE_IDLE    = 3'b111;

  localparam logic [STEP_W-1:0] STEP_ONE     = 7'd1;
  localparam logic [STEP_W-1:0] STEP_TEN     = 7'd10;
  localparam logic [STEP_W-1:0] STEP_HUNDRED = 7'd100;
endpackage

// File: rtl/btn_step_detect.sv
module btn_step_detect
  import step_count_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BTN_W-1:0]  btn_n,
  output logic [STEP_W-1:0] step
);
  logic [BTN_W-1:0] sync_q;
  logic [BTN_W-1:0] prev_q;

  // One register stage on the raw bus, then a copy of the previous value
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= CODE_IDLE;
      prev_q <= CODE_IDLE;
    end else begin
      sync_q <= btn_n;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    step = '0;
    if (sync_q != prev_q) begin
      unique case (sync_q)
        CODE_ONE:     step = STEP_ONE;
        CODE_TEN:     step = STEP_TEN;
        CODE_HUNDRED: step = STEP_HUNDRED;
        default:      step = '0;
      endcase
    end
  end
endmodule

// File: rtl/wrap_accum.sv
module wrap_accum
  import step_count_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STEP_W-1:0]  step,
  output logic [TOTAL_W-1:0] total
);
  localparam logic [TOTAL_W:0] LIM_V = (TOTAL_W+1)'(LIMIT);

  logic [TOTAL_W:0]   sum_raw;
  logic [TOTAL_W-1:0] sum_wrap;

  always_comb begin
    sum_raw  = {1'b0, total} + {{(TOTAL_W+1-STEP_W){1'b0}}, step};
    sum_wrap = (sum_raw >= LIM_V) ? TOTAL_W'(sum_raw - LIM_V) : sum_raw[TOTAL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) total <= '0;
    else     total <= sum_wrap;
  end
endmodule

// File: rtl/bin_to_bcd.sv
module bin_to_bcd
  import step_count_pkg::*;
(
  input  logic [TOTAL_W-1:0]  bin,
  output logic [DIGITS*4-1:0] bcd
);
  // Shift-and-add-3, most significant input bit first
  always_comb begin
    bcd = '0;
    for (int i = TOTAL_W - 1; i >= 0; i--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (bcd[d*4 +: 4] >= 4'd5) bcd[d*4 +: 4] = bcd[d*4 +: 4] + 4'd3;
      end
      bcd = {bcd[DIGITS*4-2:0], bin[i]};
    end
  end
endmodule

// File: rtl/seven_seg_enc.sv
module seven_seg_enc (
  input  logic [3:0] digit,
  output logic [7:0] seg_n
);
  always_comb begin
    unique case (digit)
      4'd0:    seg_n = 8'b00000011;
      4'd1:    seg_n = 8'b10011111;
      4'd2:    seg_n = 8'b00100101;
      4'd3:    seg_n = 8'b00001101;
      4'd4:    seg_n = 8'b10011001;
      4'd5:    seg_n = 8'b01001001;
      4'd6:    seg_n = 8'b01000001;
      4'd7:    seg_n = 8'b00011111;
      4'd8:    seg_n = 8'b00000001;
      4'd9:    seg_n = 8'b00011001;
      default: seg_n = 8'b11111111;
    endcase
  end
endmodule

// File: rtl/step_count_display.sv
module step_count_display
  import step_count_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [BTN_W-1:0] btn_n,
  output logic [7:0]       seg_thou,
  output logic [7:0]       seg_hund,
  output logic [7:0]       seg_tens,
  output logic [7:0]       seg_ones,
  output logic             rst_led
);
  logic [STEP_W-1:0]  step;
  logic [TOTAL_W-1:0] total;
  logic [DIGITS*4-1:0] bcd;
  logic [7:0]         seg_all [DIGITS];

  btn_step_detect u_det (.clk(clk), .rst(rst), .btn_n(btn_n), .step(step));
  wrap_accum      u_acc (.clk(clk), .rst(rst), .step(step), .total(total));
  bin_to_bcd      u_bcd (.bin(total), .bcd(bcd));

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    seven_seg_enc u_enc (.digit(bcd[d*4 +: 4]), .seg_n(seg_all[d]));
  end

  assign seg_ones = seg_all[0];
  assign seg_tens = seg_all[1];
  assign seg_hund = seg_all[2];
  assign seg_thou = seg_all[3];
  assign rst_led  = rst;
endmodule

// File: rtl/step_count_display_chk.sv
module step_count_display_chk
  import step_count_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [STEP_W-1:0]  step,
  input logic [TOTAL_W-1:0] total,
  input logic [7:0]         seg_thou,
  input logic [7:0]         seg_hund,
  input logic [7:0]         seg_tens,
  input logic [7:0]         seg_ones
);
  AST_TOTAL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(total) < LIMIT) else $error("total out of range"); // R6

  AST_NO_STEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> $stable(total)) else $error("total moved without step"); // R4

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((32'(total) + LIMIT - 32'($past(total))) % LIMIT) inside {0, 1, 10, 100}))
    else $error("illegal step"); // R2

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ({seg_thou, seg_hund, seg_tens, seg_ones} == {4{8'b00000011}}))
    else $error("display not zero after reset"); // R1
endmodule

bind step_count_display step_count_display_chk chk_i (
  .clk(clk), .rst(rst), .step(step), .total(total),
  .seg_thou(seg_thou), .seg_hund(seg_hund), .seg_tens(seg_tens), .seg_ones(seg_ones)
);

// File: tb/step_count_display_tb_top.sv
`timescale 1ns/1ps
module step_count_display_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] btn_n = 3'b111;
  logic [7:0] seg_thou, seg_hund, seg_tens, seg_ones;
  logic       rst_led;
  int         n_run = 0;
  int         n_fail = 0;
  int         model = 0;

  always #5 clk = ~clk;

  step_count_display dut_i (
    .clk(clk), .rst(rst), .btn_n(btn_n),
    .seg_thou(seg_thou), .seg_hund(seg_hund), .seg_tens(seg_tens), .seg_ones(seg_ones),
    .rst_led(rst_led)
  );

  function automatic logic [7:0] pat(input int dg);
    case (dg)
      0: pat = 8'b00000011;  1: pat = 8'b10011111;
      2: pat = 8'b00100101;  3: pat = 8'b00001101;
      4: pat = 8'b10011001;  5: pat = 8'b01001001;
      6: pat = 8'b01000001;  7: pat = 8'b00011111;
      8: pat = 8'b00000001;  9: pat = 8'b00011001;
      default: pat = 8'b11111111;
    endcase
  endfunction

  task automatic check_disp(input int value, input string tag);
    logic [31:0] exp_v, act_v;
    exp_v = {pat(value / 1000 % 10), pat(value / 100 % 10), pat(value / 10 % 10), pat(value % 10)};
    act_v = {seg_thou, seg_hund, seg_tens, seg_ones};
    n_run++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: display %h expected %h (total %0d)", tag, act_v, exp_v, value);
    end
  endtask

  task automatic check_led(input logic exp_v, input string tag);
    n_run++;
    if (rst_led !== exp_v) begin
      n_fail++;
      $display("FAIL %s: rst_led %b expected %b", tag, rst_led, exp_v);
    end
  endtask

  // Drive a code, wait two edges (sync + compare), model the step
  task automatic drive(input logic [2:0] code, input int add);
    @(negedge clk) btn_n = code;
    repeat (2) @(negedge clk);
    model = (model + add) % 10000;
  endtask

  task automatic do_reset(input logic [2:0] held);
    @(negedge clk) begin rst = 1'b1; btn_n = held; end
    repeat (3) @(negedge clk);
    check_led(1'b1, "R1 led during reset");
    check_disp(0, "R1 zero during reset");
    rst = 1'b0;
    model = 0;
  endtask

  initial begin : watchdog
    #2000000;
    n_fail++;
    $display("FAIL watchdog: timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    do_reset(3'b111);
    @(negedge clk);
    check_led(1'b0, "R1 led after reset");
    check_disp(0, "R1 zero after reset");

    // R5 latency: unchanged after one edge, updated after two
    @(negedge clk) btn_n = 3'b110;
    @(negedge clk) check_disp(0, "R5 one edge");
    @(negedge clk) begin model = 1; check_disp(1, "R5 two edges / R2 +1"); end
    repeat (5) @(negedge clk);
    check_disp(1, "R4 held");
    drive(3'b111, 0);   check_disp(model, "R3 release");
    drive(3'b101, 10);  check_disp(model, "R2 +10");
    drive(3'b011, 100); check_disp(model, "R2 +100");
    drive(3'b110, 1);   check_disp(model, "R4 direct change");
    drive(3'b100, 0);   check_disp(model, "R3 two pressed");
    drive(3'b000, 0);   check_disp(model, "R3 three pressed");
    drive(3'b010, 0);   check_disp(model, "R3 two pressed b");
    drive(3'b111, 0);   check_disp(model, "R3 idle");

    // R9 button held through reset steps once afterwards
    do_reset(3'b011);
    repeat (2) @(negedge clk);
    model = 100;
    check_disp(model, "R9 held through reset");
    repeat (4) @(negedge clk);
    check_disp(model, "R9 no second step");

    // R6/R7/R8 exhaustive sweep with +1 presses, wrapping to 0
    do_reset(3'b111);
    for (int k = 0; k < 10000; k++) begin
      drive(3'b110, 1);
      check_disp(model, "R7 R8 sweep");
      drive(3'b111, 0);
    end
    check_disp(0, "R6 wrap to zero");

    // R6 wrap with +100 from 9950
    do_reset(3'b111);
    for (int k = 0; k < 99; k++) begin drive(3'b011, 100); drive(3'b111, 0); end
    for (int k = 0; k < 5; k++)  begin drive(3'b101, 10);  drive(3'b111, 0); end
    check_disp(9950, "R6 pre-wrap");
    drive(3'b011, 100);
    check_disp(50, "R6 wrap +100");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule